// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the arithmetic and logic stage of a small RISC core. Each cycle it may take one operation, from two 32-bit register values, a raw 16-bit immediate field, two register indices and the current status word. One clock edge later it returns the result, the index of the register that receives it, a write enable, and the updated status word. The operations are addition and the bitwise OR, AND, XOR and NOT. They take either two registers or a register and an immediate, and each immediate form has its own extension rule.

The status word carries four condition flags in its low nibble. Addition recomputes all four. The bitwise operations recompute zero and sign, clear overflow and keep carry. Every status bit above the flag nibble is copied from the incoming word. A valid strobe qualifies each operation. Without it, or with an unassigned operation code, nothing is written and the status output holds.

Top module: `int_exec_unit`

## Requirements
- R1: `op_sel` codes are 0 add reg+reg, 1 add short immediate, 2 add long immediate, 3 OR reg, 4 OR immediate, 5 AND reg, 6 AND immediate, 7 XOR reg, 8 XOR immediate, 9 NOT. Status flags sit at bit 0 zero, bit 1 sign, bit 2 overflow and bit 3 carry. An add sets zero when the 32-bit sum is 0 and sign from sum bit 31. It sets carry on unsigned carry-out, and overflow when both operands share a sign that the sum does not.
- R2: Register add (code 0) computes `src_b + src_a` and writes it to `idx_b`.
- R3: Short immediate add (code 1) sign-extends `imm_raw[4:0]`, adds `src_b`, and writes the sum to `idx_b`. The upper immediate bits have no effect, and 0x10 extends to -16.
- R4: Long immediate add (code 2) sign-extends `imm_raw[15:0]`, adds `src_a`, and writes the sum to `idx_d`.
- R5: The logic immediate forms (codes 4, 6, 8) zero-extend `imm_raw[15:0]`, combine it with `src_a`, and write to `idx_d`.
- R6: The register logic forms (codes 3, 5, 7) combine `src_b` with `src_a` and write to `idx_b`. NOT (code 9) inverts `src_a`, ignores `src_b`, and writes to `idx_b`.
- R7: Every logic operation sets zero and sign from its result, forces overflow to 0, and copies carry from `psw_in`.
- R8: On any executed operation, `psw_out[31:4]` equals `psw_in[31:4]`.
- R9: When `op_valid` is low, the next cycle has `res_we` low, and `psw_out`, `res_val` and `res_idx` hold.
- R10: A valid operation code above 9 behaves like R9.
- R11: Results appear one clock after the operation is presented. After reset, `res_we`, `res_val`, `res_idx` and `psw_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation this cycle |
| op_sel | input | 4 | Operation code (R1) |
| src_a | input | 32 | First register value |
| src_b | input | 32 | Second register value |
| imm_raw | input | 16 | Raw immediate field |
| idx_b | input | 5 | Index of the second register field |
| idx_d | input | 5 | Separate destination index for the three-operand forms |
| psw_in | input | 32 | Current status word |
| res_val | output | 32 | Result |
| res_idx | output | 5 | Destination register index |
| res_we | output | 1 | Result write enable |
| psw_out | output | 32 | Updated status word |

## Verification
The add path is driven with sums that produce each flag on its own and in combination:

- a signed-positive wrap that gives overflow without carry;
- an all-ones plus one that gives carry and zero;
- two minimum negatives that give carry, overflow and zero together;
- small values that give no flag at all.

The two immediate adds use a negative 5-bit field, once with its upper bits set and once clear, and a negative 16-bit field. These show that the extension is signed, that it uses the right width, and that the right destination field is picked. The logic operations are run with carry and overflow preset in `psw_in`, to separate carry being kept from overflow being cleared. Zero and sign results are produced in both the immediate and the register forms. Idle cycles and unassigned codes are presented with a different incoming status word, to show that the held outputs do not move.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    EXU_ADD    = 4'd0,
    EXU_ADDS   = 4'd1,
    EXU_ADDL   = 4'd2,
    EXU_OR     = 4'd3,
    EXU_ORI    = 4'd4,
    EXU_AND    = 4'd5,
    EXU_ANDI   = 4'd6,
    EXU_XOR    = 4'd7,
    EXU_XORI   = 4'd8,
    EXU_NOT    = 4'd9
  } exu_op_e;

  localparam logic [3:0] EXU_LAST_OP = 4'd9;

  typedef enum logic [1:0] {
    LFN_OR  = 2'd0,
    LFN_AND = 2'd1,
    LFN_XOR = 2'd2,
    LFN_INV = 2'd3
  } lfn_e;

  localparam int FLG_Z  = 0;
  localparam int FLG_S  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_CY = 3;

  typedef struct packed {
    logic known;
    logic is_add;
    lfn_e lfn;
  } exu_dec_t;

endpackage

// File: rtl/exu_opsel.sv
module exu_opsel #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5,
  parameter int AW     = 5
) (
  input  logic [3:0]       op_sel,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm_raw,
  input  logic [AW-1:0]    idx_b,
  input  logic [AW-1:0]    idx_d,
  output logic [XLEN-1:0]  opnd_x,
  output logic [XLEN-1:0]  opnd_y,
  output logic [AW-1:0]    dst_idx,
  output exu_pkg::exu_dec_t dec
);
  import exu_pkg::*;

  localparam int SPAD = XLEN - SIMM_W;
  localparam int LPAD = XLEN - IMM_W;

  logic [XLEN-1:0] imm_s5;
  logic [XLEN-1:0] imm_s16;
  logic [XLEN-1:0] imm_z16;

  assign imm_s5  = {{SPAD{imm_raw[SIMM_W-1]}}, imm_raw[SIMM_W-1:0]};
  assign imm_s16 = {{LPAD{imm_raw[IMM_W-1]}}, imm_raw};
  assign imm_z16 = {{LPAD{1'b0}}, imm_raw};

  always_comb begin
    opnd_x     = src_b;
    opnd_y     = src_a;
    dst_idx    = idx_b;
    dec.known  = 1'b1;
    dec.is_add = 1'b0;
    dec.lfn    = LFN_OR;
    case (exu_op_e'(op_sel))
      EXU_ADD:  dec.is_add = 1'b1;
      EXU_ADDS: begin dec.is_add = 1'b1; opnd_y = imm_s5; end
      EXU_ADDL: begin dec.is_add = 1'b1; opnd_x = src_a; opnd_y = imm_s16; dst_idx = idx_d; end
      EXU_OR:   dec.lfn = LFN_OR;
      EXU_ORI:  begin dec.lfn = LFN_OR;  opnd_x = src_a; opnd_y = imm_z16; dst_idx = idx_d; end
      EXU_AND:  dec.lfn = LFN_AND;
      EXU_ANDI: begin dec.lfn = LFN_AND; opnd_x = src_a; opnd_y = imm_z16; dst_idx = idx_d; end
      EXU_XOR:  dec.lfn = LFN_XOR;
      EXU_XORI: begin dec.lfn = LFN_XOR; opnd_x = src_a; opnd_y = imm_z16; dst_idx = idx_d; end
      EXU_NOT:  begin dec.lfn = LFN_INV; opnd_x = src_a; end
      default:  dec.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd_x,
  input  logic [XLEN-1:0] opnd_y,
  output logic [XLEN-1:0] sum,
  output logic            carry,
  output logic            ovf
);
  logic [XLEN:0] wide;

  assign wide  = {1'b0, opnd_x} + {1'b0, opnd_y};
  assign sum   = wide[XLEN-1:0];
  assign carry = wide[XLEN];
  assign ovf   = (opnd_x[XLEN-1] == opnd_y[XLEN-1]) && (wide[XLEN-1] != opnd_x[XLEN-1]);

endmodule

// File: rtl/exu_logic.sv
module exu_logic #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd_x,
  input  logic [XLEN-1:0] opnd_y,
  input  exu_pkg::lfn_e   lfn,
  output logic [XLEN-1:0] res
);
  import exu_pkg::*;

  always_comb begin
    case (lfn)
      LFN_OR:  res = opnd_x | opnd_y;
      LFN_AND: res = opnd_x & opnd_y;
      LFN_XOR: res = opnd_x ^ opnd_y;
      default: res = ~opnd_x;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5,
  parameter int AW     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_sel,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm_raw,
  input  logic [AW-1:0]    idx_b,
  input  logic [AW-1:0]    idx_d,
  input  logic [XLEN-1:0]  psw_in,
  output logic [XLEN-1:0]  res_val,
  output logic [AW-1:0]    res_idx,
  output logic             res_we,
  output logic [XLEN-1:0]  psw_out
);
  import exu_pkg::*;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [XLEN-1:0] opnd_x, opnd_y, add_sum, lg_res;
  logic [AW-1:0]   dst_idx;
  logic            add_cy, add_ov;
  exu_dec_t        dec;

  logic            nxt_we;
  logic [XLEN-1:0] nxt_val;
  logic [XLEN-1:0] nxt_psw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  exu_opsel #(.XLEN(XLEN), .IMM_W(IMM_W), .SIMM_W(SIMM_W), .AW(AW)) u_opsel (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_raw(imm_raw),
    .idx_b(idx_b), .idx_d(idx_d), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .dst_idx(dst_idx), .dec(dec)
  );

  exu_adder #(.XLEN(XLEN)) u_adder (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .sum(add_sum), .carry(add_cy), .ovf(add_ov)
  );

  exu_logic #(.XLEN(XLEN)) u_logic (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .lfn(dec.lfn), .res(lg_res)
  );

  always_comb begin
    nxt_we          = op_valid & dec.known;
    nxt_val         = dec.is_add ? add_sum : lg_res;
    nxt_psw         = psw_in;
    nxt_psw[FLG_Z]  = (nxt_val == '0);
    nxt_psw[FLG_S]  = nxt_val[XLEN-1];
    nxt_psw[FLG_OV] = dec.is_add & add_ov;
    nxt_psw[FLG_CY] = dec.is_add ? add_cy : psw_in[FLG_CY];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_we  <= 1'b0;
      res_val <= '0;
      res_idx <= '0;
      psw_out <= '0;
    end else begin
      res_we <= nxt_we;
      if (nxt_we) begin
        res_val <= nxt_val;
        res_idx <= dst_idx;
        psw_out <= nxt_psw;
      end
    end
  end

endmodule

// File: rtl/exu_chk.sv
module exu_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_sel,
  input logic [AW-1:0]    idx_d,
  input logic [XLEN-1:0]  psw_in,
  input logic [XLEN-1:0]  res_val,
  input logic [AW-1:0]    res_idx,
  input logic             res_we,
  input logic [XLEN-1:0]  psw_out
);
  import exu_pkg::*;

  logic is_known, is_logic;
  assign is_known = op_sel <= EXU_LAST_OP;
  assign is_logic = is_known && (op_sel >= 4'(EXU_OR));

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_we); // R9
  AST_IDLE_PSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(psw_out)); // R9
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_known) |=> (!res_we && $stable(psw_out))); // R10
  AST_LOGIC_OV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic) |=> !psw_out[FLG_OV]); // R7
  AST_LOGIC_CY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic) |=> (psw_out[FLG_CY] == $past(psw_in[FLG_CY]))); // R7
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_known) |=> (psw_out[XLEN-1:4] == $past(psw_in[XLEN-1:4]))); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (psw_out[FLG_Z] == (res_val == '0))); // R1
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (psw_out[FLG_S] == res_val[XLEN-1])); // R1
  AST_LONG_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'(EXU_ADDL)) |=> (res_we && res_idx == $past(idx_d))); // R4

endmodule

bind int_exec_unit exu_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .idx_d(idx_d),
  .psw_in(psw_in), .res_val(res_val), .res_idx(res_idx), .res_we(res_we),
  .psw_out(psw_out)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0, psw_in = '0;
  logic [15:0] imm_raw = '0;
  logic [4:0]  idx_b = '0, idx_d = '0;
  logic [31:0] res_val, psw_out;
  logic [4:0]  res_idx;
  logic        res_we;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm_raw(imm_raw), .idx_b(idx_b),
    .idx_d(idx_d), .psw_in(psw_in), .res_val(res_val), .res_idx(res_idx),
    .res_we(res_we), .psw_out(psw_out)
  );

  task automatic check(input string req, input logic [31:0] e_val,
                       input logic [4:0] e_idx, input logic e_we,
                       input logic [31:0] e_psw);
    total++;
    if (res_val !== e_val || res_idx !== e_idx || res_we !== e_we || psw_out !== e_psw) begin
      bad++;
      $display("FAIL %s: val=%h idx=%0d we=%b psw=%h expected val=%h idx=%0d we=%b psw=%h",
               req, res_val, res_idx, res_we, psw_out, e_val, e_idx, e_we, e_psw);
    end
  endtask

  // drive after a falling edge, sample at the next falling edge
  task automatic run(input logic v, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [15:0] imm,
                     input logic [4:0] ib, input logic [4:0] id, input logic [31:0] p);
    @(negedge clk);
    op_valid = v; op_sel = op; src_a = a; src_b = b; imm_raw = imm;
    idx_b = ib; idx_d = id; psw_in = p;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 reset", 32'h0, 5'd0, 1'b0, 32'h0);
  endtask

  task automatic t_add_reg;
    run(1, 4'd0, 32'h1, 32'h7FFFFFFF, 16'h0, 5'd3, 5'd9, 32'h0);
    check("R1 R2 signed wrap OV", 32'h80000000, 5'd3, 1'b1, 32'h6);
    run(1, 4'd0, 32'h1, 32'hFFFFFFFF, 16'h0, 5'd4, 5'd9, 32'h0);
    check("R1 R2 carry zero", 32'h0, 5'd4, 1'b1, 32'h9);
    run(1, 4'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd5, 5'd9, 32'h0);
    check("R1 all of CY OV Z", 32'h0, 5'd5, 1'b1, 32'hD);
    run(1, 4'd0, 32'd7, 32'd5, 16'h0, 5'd6, 5'd9, 32'hF);
    check("R1 no flags", 32'd12, 5'd6, 1'b1, 32'h0);
  endtask

  task automatic t_add_short;
    run(1, 4'd1, 32'hDEAD0000, 32'd20, 16'h0010, 5'd7, 5'd30, 32'h0);
    check("R3 imm5 0x10 is -16", 32'd4, 5'd7, 1'b1, 32'h8);
    run(1, 4'd1, 32'h0, 32'd20, 16'hFFF0, 5'd7, 5'd30, 32'h0);
    check("R3 upper imm bits ignored", 32'd4, 5'd7, 1'b1, 32'h8);
    run(1, 4'd1, 32'h0, 32'd3, 16'h0010, 5'd8, 5'd30, 32'h0);
    check("R3 negative sum", 32'hFFFFFFF3, 5'd8, 1'b1, 32'h2);
  endtask

  task automatic t_add_long;
    run(1, 4'd2, 32'h00010000, 32'h0, 16'h8000, 5'd1, 5'd17, 32'h0);
    check("R4 imm16 sign extend", 32'h00008000, 5'd17, 1'b1, 32'h8);
    run(1, 4'd2, 32'h1, 32'h0, 16'h7FFF, 5'd1, 5'd18, 32'h0);
    check("R4 positive imm16", 32'h00008000, 5'd18, 1'b1, 32'h0);
  endtask

  task automatic t_logic_imm;
    run(1, 4'd4, 32'h80000000, 32'h0, 16'h8001, 5'd2, 5'd20, 32'hC);
    check("R5 R7 ori zero extend", 32'h80008001, 5'd20, 1'b1, 32'hA);
    run(1, 4'd6, 32'hFFFF0000, 32'h0, 16'hFFFF, 5'd2, 5'd21, 32'h4);
    check("R5 R7 andi zero", 32'h0, 5'd21, 1'b1, 32'h1);
    run(1, 4'd8, 32'h0000FFFF, 32'h0, 16'hFFFF, 5'd2, 5'd22, 32'h8);
    check("R5 R7 xori keeps CY", 32'h0, 5'd22, 1'b1, 32'h9);
  endtask

  task automatic t_logic_reg;
    run(1, 4'd3, 32'h000000F0, 32'h0F0F0000, 16'hFFFF, 5'd10, 5'd29, 32'h0);
    check("R6 or reg", 32'h0F0F00F0, 5'd10, 1'b1, 32'h0);
    run(1, 4'd5, 32'h80000001, 32'hF0000000, 16'h0, 5'd11, 5'd29, 32'h8);
    check("R6 R7 and reg sign", 32'h80000000, 5'd11, 1'b1, 32'hA);
    run(1, 4'd7, 32'h12345678, 32'h12345678, 16'h0, 5'd12, 5'd29, 32'h4);
    check("R6 R7 xor reg zero", 32'h0, 5'd12, 1'b1, 32'h1);
    run(1, 4'd9, 32'hFFFFFFFF, 32'h5555AAAA, 16'h0, 5'd13, 5'd29, 32'h0);
    check("R6 not to zero", 32'h0, 5'd13, 1'b1, 32'h1);
    run(1, 4'd9, 32'h0, 32'h12345678, 16'h0, 5'd14, 5'd29, 32'hC);
    check("R6 R7 not to ones", 32'hFFFFFFFF, 5'd14, 1'b1, 32'hA);
  endtask

  task automatic t_pass;
    run(1, 4'd0, 32'd1, 32'd1, 16'h0, 5'd15, 5'd0, 32'hABCDEF00);
    check("R8 add passes upper bits", 32'd2, 5'd15, 1'b1, 32'hABCDEF00);
    run(1, 4'd3, 32'h0, 32'h0, 16'h0, 5'd16, 5'd0, 32'h12345678);
    check("R8 logic passes upper bits", 32'h0, 5'd16, 1'b1, 32'h12345679);
  endtask

  task automatic t_idle;
    run(1, 4'd0, 32'd2, 32'd3, 16'h0, 5'd19, 5'd0, 32'h0);
    check("R11 setup", 32'd5, 5'd19, 1'b1, 32'h0);
    run(0, 4'd0, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd1, 5'd2, 32'hFFFFFFF0);
    check("R9 idle holds", 32'd5, 5'd19, 1'b0, 32'h0);
    run(1, 4'hF, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd1, 5'd2, 32'hFFFFFFF0);
    check("R10 undefined code", 32'd5, 5'd19, 1'b0, 32'h0);
    run(1, 4'hA, 32'h1, 32'd1, 16'h0, 5'd1, 5'd2, 32'h0000FFF0);
    check("R10 code 10", 32'd5, 5'd19, 1'b0, 32'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add_reg();
    t_add_short();
    t_add_long();
    t_logic_imm();
    t_logic_reg();
    t_pass();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule